// File: doc/BRIEF.md
# Pseudo-channel command dispatcher

This block receives one shared memory-channel command interface and splits it between two pseudo-channels that run independently of each other. Two half-word streams arrive each clock cycle on the row bus (one captured on the rising edge, one on the falling edge), and two more on the column bus. Every half-word carries its own parity bit. The block assembles activates, which take two cycles, checks parity and routes each decoded command to the pseudo-channel named by one select bit. Each pseudo-channel has its own output ports, its own address space and its own table of open rows.

For each pseudo-channel the block keeps one open-row register and one valid flag per bank. A read or write to a bank that is not open is rejected as a protocol error. Every read or write that is forwarded opens a data-valid window. The window is fixed by the four-beat burst: two clock cycles at double data rate, starting a parameterised number of cycles after the command. A surrounding scheduler uses the routed outputs to drive each pseudo-channel's data path and to time its data beats.

Top module: `pcd_dispatch`

## Requirements
- R1: Each row half-word has even parity together with its parity bit. A cycle in which either row half-word fails raises `row_par_err` in the next cycle, forwards no row command, and discards any activate that was half captured.
- R2: A column cycle in which either half-word fails even parity raises `col_par_err` in the next cycle and forwards no column command.
- R3: Bit 5 of the rising-edge half-word is the pseudo-channel select. A value of 0 sends the command only to the index-0 outputs and a value of 1 only to the index-1 outputs.
- R4: Row opcode (bits 7:6 of the rising half-word) 01 starts an activate. Bank is bits 4:2 and the falling half-word gives row bits 13:6. The next cycle must carry opcode 11, with bits 5:0 of its rising half-word as row bits 5:0. The activate appears on `pc_row_*` one cycle after that second cycle, with `pc_row_act` high.
- R5: Row opcode 10 is a single-cycle precharge. It is forwarded with `pc_row_act` low and closes its bank in the selected pseudo-channel.
- R6: If a row cycle with an opcode other than 11 arrives while an activate waits for its second cycle, `proto_err` is raised, the pending activate is dropped and the new cycle is decoded as a fresh command.
- R7: A read (column opcode 01) or write (10) to a bank that is closed in the selected pseudo-channel raises `proto_err` and is not forwarded. This includes a bank whose activate completes in that same cycle.
- R8: A read or write to an open bank is forwarded on `pc_col_*` one cycle later. It carries the bank (bits 4:2), the column address {rising bits 1:0, falling half-word}, `pc_col_wr` high for a write, and the open row of that bank.
- R9: When `pc_col_vld[p]` is high in cycle C, `pc_dvalid[p]` is high in cycles C+DATA_LAT and C+DATA_LAT+1, which is the four-beat burst.
- R10: Row and column commands in the same cycle for different pseudo-channels are both forwarded. Bank state is kept separately for each pseudo-channel.
- R11: During reset every output is low and all banks in both pseudo-channels are closed.
- R12: Row opcode 11 with no activate pending has no effect, and row opcode 00 is a no-op.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| row_rise | input | HW | Row half-word captured on the rising edge |
| row_rise_par | input | 1 | Parity bit of row_rise |
| row_fall | input | HW | Row half-word captured on the falling edge |
| row_fall_par | input | 1 | Parity bit of row_fall |
| col_rise | input | HW | Column half-word captured on the rising edge |
| col_rise_par | input | 1 | Parity bit of col_rise |
| col_fall | input | HW | Column half-word captured on the falling edge |
| col_fall_par | input | 1 | Parity bit of col_fall |
| pc_row_vld | output | 2 | Row command valid, one bit per pseudo-channel |
| pc_row_act | output | 2 | 1 = activate, 0 = precharge |
| pc_row_bank | output | 2 x BANK_W | Bank of the row command |
| pc_row_addr | output | 2 x ROW_W | Row address of an activate |
| pc_col_vld | output | 2 | Column command valid |
| pc_col_wr | output | 2 | 1 = write, 0 = read |
| pc_col_bank | output | 2 x BANK_W | Bank of the column command |
| pc_col_addr | output | 2 x COL_W | Column address |
| pc_col_row | output | 2 x ROW_W | Open row of the addressed bank |
| pc_dvalid | output | 2 | Data-valid window of the burst |
| row_par_err | output | 1 | Row parity error pulse |
| col_par_err | output | 1 | Column parity error pulse |
| proto_err | output | 1 | Protocol error pulse |

## Verification
The assertions take for granted that reset is applied before any command and that the parity inputs settle with their half-words before the rising edge. Nothing else about the input is assumed: bad parity, interrupted activates and accesses to closed banks are legal stimulus that the block must flag. The bench drives each half-word and its parity at the falling edge of the bench clock and injects parity faults on purpose through a per-vector flag. It places commands that overlap only at the cycle boundaries the requirements name: activate completion followed by a column command in the same cycle, and a row and a column command for different pseudo-channels.

// File: rtl/pcd_pkg.sv
package pcd_pkg;

   typedef enum logic [1:0] {
      ROP_NOP  = 2'b00,
      ROP_ACT  = 2'b01,
      ROP_PRE  = 2'b10,
      ROP_CONT = 2'b11
   } row_op_t;

   typedef enum logic [1:0] {
      COP_NOP = 2'b00,
      COP_RD  = 2'b01,
      COP_WR  = 2'b10,
      COP_RSV = 2'b11
   } col_op_t;

   localparam int unsigned NUM_PC = 2;

endpackage

// File: rtl/pcd_row_asm.sv
module pcd_row_asm
   import pcd_pkg::*;
#(
   parameter int unsigned HW     = 8,
   parameter int unsigned BANK_W = 3,
   localparam int unsigned LO_W  = HW - 2,
   localparam int unsigned ROW_W = 2 * HW - 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [HW-1:0]     rise,
   input  logic              rise_par,
   input  logic [HW-1:0]     fall,
   input  logic              fall_par,
   output logic              fire,
   output logic              fire_act,
   output logic              fire_pc,
   output logic [BANK_W-1:0] fire_bank,
   output logic [ROW_W-1:0]  fire_row,
   output logic              overlap_err,
   output logic              par_err
);

   logic              par_ok;
   row_op_t           op;
   logic              sel;
   logic [BANK_W-1:0] bank;

   logic              pend_q, pend_d;
   logic              pend_pc_q, pend_pc_d;
   logic [BANK_W-1:0] pend_bank_q, pend_bank_d;
   logic [HW-1:0]     pend_hi_q, pend_hi_d;
   logic              fresh;

   assign par_ok = ~(^{rise, rise_par}) & ~(^{fall, fall_par});
   assign op     = row_op_t'(rise[HW-1 -: 2]);
   assign sel    = rise[HW-3];
   assign bank   = rise[HW-4 -: BANK_W];

   always_comb begin
      fire        = 1'b0;
      fire_act    = 1'b0;
      fire_pc     = sel;
      fire_bank   = bank;
      fire_row    = '0;
      overlap_err = 1'b0;
      fresh       = 1'b0;
      pend_d      = pend_q;
      pend_pc_d   = pend_pc_q;
      pend_bank_d = pend_bank_q;
      pend_hi_d   = pend_hi_q;
      if (!par_ok) begin
         pend_d = 1'b0;
      end else begin
         fresh = 1'b1;
         if (pend_q) begin
            pend_d = 1'b0;
            if (op == ROP_CONT) begin
               fire      = 1'b1;
               fire_act  = 1'b1;
               fire_pc   = pend_pc_q;
               fire_bank = pend_bank_q;
               fire_row  = {pend_hi_q, rise[LO_W-1:0]};
               fresh     = 1'b0;
            end else begin
               overlap_err = 1'b1;
            end
         end
         if (fresh) begin
            case (op)
               ROP_ACT: begin
                  pend_d      = 1'b1;
                  pend_pc_d   = sel;
                  pend_bank_d = bank;
                  pend_hi_d   = fall;
               end
               ROP_PRE: fire = 1'b1;
               default: ;
            endcase
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q      <= 1'b0;
         pend_pc_q   <= 1'b0;
         pend_bank_q <= '0;
         pend_hi_q   <= '0;
         par_err     <= 1'b0;
      end else begin
         pend_q      <= pend_d;
         pend_pc_q   <= pend_pc_d;
         pend_bank_q <= pend_bank_d;
         pend_hi_q   <= pend_hi_d;
         par_err     <= ~par_ok;
      end
   end

endmodule

// File: rtl/pcd_pc_track.sv
module pcd_pc_track #(
   parameter int unsigned BANK_W    = 3,
   parameter int unsigned ROW_W     = 14,
   parameter int unsigned COL_W     = 10,
   parameter int unsigned DATA_LAT  = 3,
   parameter int unsigned BURST_CYC = 2,
   localparam int unsigned NB       = 1 << BANK_W,
   localparam int unsigned SR_W     = DATA_LAT + BURST_CYC - 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              row_fire,
   input  logic              row_act,
   input  logic [BANK_W-1:0] row_bank,
   input  logic [ROW_W-1:0]  row_addr,
   input  logic              col_req,
   input  logic              col_wr,
   input  logic [BANK_W-1:0] col_bank,
   input  logic [COL_W-1:0]  col_addr,
   output logic              col_err,
   output logic              o_row_vld,
   output logic              o_row_act,
   output logic [BANK_W-1:0] o_row_bank,
   output logic [ROW_W-1:0]  o_row_addr,
   output logic              o_col_vld,
   output logic              o_col_wr,
   output logic [BANK_W-1:0] o_col_bank,
   output logic [COL_W-1:0]  o_col_addr,
   output logic [ROW_W-1:0]  o_col_row,
   output logic              dvalid
);

   logic [NB-1:0]            open_vld;
   logic [NB-1:0][ROW_W-1:0] open_row;
   logic                     col_ok;
   logic [SR_W-1:0]          win_sr;

   assign col_ok  = col_req &  open_vld[col_bank];
   assign col_err = col_req & ~open_vld[col_bank];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         o_row_vld  <= 1'b0;
         o_row_act  <= 1'b0;
         o_row_bank <= '0;
         o_row_addr <= '0;
         o_col_vld  <= 1'b0;
         o_col_wr   <= 1'b0;
         o_col_bank <= '0;
         o_col_addr <= '0;
         o_col_row  <= '0;
      end else begin
         o_row_vld  <= row_fire;
         o_row_act  <= row_fire & row_act;
         o_row_bank <= row_bank;
         o_row_addr <= row_addr;
         o_col_vld  <= col_ok;
         o_col_wr   <= col_wr;
         o_col_bank <= col_bank;
         o_col_addr <= col_addr;
         o_col_row  <= open_row[col_bank];
      end
   end

   for (genvar b = 0; b < NB; b++) begin : g_bank
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            open_vld[b] <= 1'b0;
            open_row[b] <= '0;
         end else if (row_fire && row_bank == BANK_W'(b)) begin
            open_vld[b] <= row_act;
            if (row_act) open_row[b] <= row_addr;
         end
      end
   end

   if (SR_W == 1) begin : g_win_short
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) win_sr <= '0;
         else        win_sr <= o_col_vld;
      end
   end else begin : g_win_long
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) win_sr <= '0;
         else        win_sr <= {win_sr[SR_W-2:0], o_col_vld};
      end
   end

   assign dvalid = |win_sr[DATA_LAT-1 +: BURST_CYC];

endmodule

// File: rtl/pcd_dispatch.sv
module pcd_dispatch
   import pcd_pkg::*;
#(
   parameter int unsigned HW        = 8,
   parameter int unsigned BANK_W    = 3,
   parameter int unsigned BURST_LEN = 4,
   parameter int unsigned DATA_LAT  = 3,
   localparam int unsigned ROW_W     = 2 * HW - 2,
   localparam int unsigned COL_W     = 2 * HW - 3 - BANK_W,
   localparam int unsigned BURST_CYC = BURST_LEN / 2
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic [HW-1:0]                    row_rise,
   input  logic                             row_rise_par,
   input  logic [HW-1:0]                    row_fall,
   input  logic                             row_fall_par,
   input  logic [HW-1:0]                    col_rise,
   input  logic                             col_rise_par,
   input  logic [HW-1:0]                    col_fall,
   input  logic                             col_fall_par,
   output logic [NUM_PC-1:0]                pc_row_vld,
   output logic [NUM_PC-1:0]                pc_row_act,
   output logic [NUM_PC-1:0][BANK_W-1:0]    pc_row_bank,
   output logic [NUM_PC-1:0][ROW_W-1:0]     pc_row_addr,
   output logic [NUM_PC-1:0]                pc_col_vld,
   output logic [NUM_PC-1:0]                pc_col_wr,
   output logic [NUM_PC-1:0][BANK_W-1:0]    pc_col_bank,
   output logic [NUM_PC-1:0][COL_W-1:0]     pc_col_addr,
   output logic [NUM_PC-1:0][ROW_W-1:0]     pc_col_row,
   output logic [NUM_PC-1:0]                pc_dvalid,
   output logic                             row_par_err,
   output logic                             col_par_err,
   output logic                             proto_err
);

   if (BURST_LEN != 4) begin : g_bad_burst
      $error("pcd_dispatch: burst length must be 4 in pseudo-channel mode");
   end
   if (HW < BANK_W + 4) begin : g_bad_width
      $error("pcd_dispatch: half-word too narrow for opcode, select and bank");
   end
   if (DATA_LAT < 1) begin : g_bad_lat
      $error("pcd_dispatch: DATA_LAT must be at least 1");
   end

   logic              r_fire, r_act, r_pc, r_ovl;
   logic [BANK_W-1:0] r_bank;
   logic [ROW_W-1:0]  r_row;

   pcd_row_asm #(.HW(HW), .BANK_W(BANK_W)) i_row_asm (
      .clk        (clk),
      .rst_n      (rst_n),
      .rise       (row_rise),
      .rise_par   (row_rise_par),
      .fall       (row_fall),
      .fall_par   (row_fall_par),
      .fire       (r_fire),
      .fire_act   (r_act),
      .fire_pc    (r_pc),
      .fire_bank  (r_bank),
      .fire_row   (r_row),
      .overlap_err(r_ovl),
      .par_err    (row_par_err)
   );

   logic              c_par_ok, c_go, c_wr, c_sel;
   col_op_t           c_op;
   logic [BANK_W-1:0] c_bank;
   logic [COL_W-1:0]  c_addr;
   logic [NUM_PC-1:0] c_err;

   assign c_par_ok = ~(^{col_rise, col_rise_par}) & ~(^{col_fall, col_fall_par});
   assign c_op     = col_op_t'(col_rise[HW-1 -: 2]);
   assign c_go     = c_par_ok & ((c_op == COP_RD) | (c_op == COP_WR));
   assign c_wr     = (c_op == COP_WR);
   assign c_sel    = col_rise[HW-3];
   assign c_bank   = col_rise[HW-4 -: BANK_W];
   assign c_addr   = {col_rise[HW-4-BANK_W:0], col_fall};

   for (genvar p = 0; p < NUM_PC; p++) begin : g_pc
      localparam logic SEL = 1'(p);
      pcd_pc_track #(
         .BANK_W   (BANK_W),
         .ROW_W    (ROW_W),
         .COL_W    (COL_W),
         .DATA_LAT (DATA_LAT),
         .BURST_CYC(BURST_CYC)
      ) i_track (
         .clk       (clk),
         .rst_n     (rst_n),
         .row_fire  (r_fire & (r_pc == SEL)),
         .row_act   (r_act),
         .row_bank  (r_bank),
         .row_addr  (r_row),
         .col_req   (c_go & (c_sel == SEL)),
         .col_wr    (c_wr),
         .col_bank  (c_bank),
         .col_addr  (c_addr),
         .col_err   (c_err[p]),
         .o_row_vld (pc_row_vld[p]),
         .o_row_act (pc_row_act[p]),
         .o_row_bank(pc_row_bank[p]),
         .o_row_addr(pc_row_addr[p]),
         .o_col_vld (pc_col_vld[p]),
         .o_col_wr  (pc_col_wr[p]),
         .o_col_bank(pc_col_bank[p]),
         .o_col_addr(pc_col_addr[p]),
         .o_col_row (pc_col_row[p]),
         .dvalid    (pc_dvalid[p])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         col_par_err <= 1'b0;
         proto_err   <= 1'b0;
      end else begin
         col_par_err <= ~c_par_ok;
         proto_err   <= r_ovl | (|c_err);
      end
   end

endmodule

// File: rtl/pcd_dispatch_chk.sv
module pcd_dispatch_chk (
   input logic       clk,
   input logic       rst_n,
   input logic [1:0] pc_row_vld,
   input logic [1:0] pc_col_vld,
   input logic [1:0] pc_dvalid,
   input logic       row_par_err,
   input logic       col_par_err
);

   assert_row_drop_R1: assert property (@(posedge clk) disable iff (!rst_n)
      row_par_err |-> (pc_row_vld == 2'b00));

   assert_col_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
      col_par_err |-> (pc_col_vld == 2'b00));

   assert_row_route_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(pc_row_vld));

   assert_col_route_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(pc_col_vld));

   assert_window0_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pc_dvalid[0]) |=> pc_dvalid[0]);

   assert_window1_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pc_dvalid[1]) |=> pc_dvalid[1]);

endmodule

bind pcd_dispatch pcd_dispatch_chk i_pcd_dispatch_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .pc_row_vld (pc_row_vld),
   .pc_col_vld (pc_col_vld),
   .pc_dvalid  (pc_dvalid),
   .row_par_err(row_par_err),
   .col_par_err(col_par_err)
);

// File: tb/test_pcd_dispatch.sv
`timescale 1ns/1ps
module test_pcd_dispatch;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [7:0] row_rise = '0, row_fall = '0, col_rise = '0, col_fall = '0;
   logic row_rise_par = 1'b0, row_fall_par = 1'b0, col_rise_par = 1'b0, col_fall_par = 1'b0;
   logic [1:0]       pc_row_vld, pc_row_act, pc_col_vld, pc_col_wr, pc_dvalid;
   logic [1:0][2:0]  pc_row_bank, pc_col_bank;
   logic [1:0][13:0] pc_row_addr, pc_col_row;
   logic [1:0][9:0]  pc_col_addr;
   logic row_par_err, col_par_err, proto_err;

   int checks = 0;
   int fails = 0;
   int cyc = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   pcd_dispatch i_pcd_dispatch (
      .clk(clk), .rst_n(rst_n),
      .row_rise(row_rise), .row_rise_par(row_rise_par),
      .row_fall(row_fall), .row_fall_par(row_fall_par),
      .col_rise(col_rise), .col_rise_par(col_rise_par),
      .col_fall(col_fall), .col_fall_par(col_fall_par),
      .pc_row_vld(pc_row_vld), .pc_row_act(pc_row_act),
      .pc_row_bank(pc_row_bank), .pc_row_addr(pc_row_addr),
      .pc_col_vld(pc_col_vld), .pc_col_wr(pc_col_wr),
      .pc_col_bank(pc_col_bank), .pc_col_addr(pc_col_addr),
      .pc_col_row(pc_col_row), .pc_dvalid(pc_dvalid),
      .row_par_err(row_par_err), .col_par_err(col_par_err), .proto_err(proto_err)
   );

   // {req, row_rise, bad_row_par, row_fall, col_rise, bad_col_par, col_fall,
   //  expected {row_vld[1:0], col_vld[1:0], proto_err, row_par_err, col_par_err}}
   localparam int NV = 16;
   localparam logic [44:0] TV [NV] = '{
      {4'd4,  8'h44, 1'b0, 8'hA5, 8'h00, 1'b0, 8'h00, 7'b00_00_0_00}, // R4 act pc0 b1, first half
      {4'd7,  8'hC3, 1'b0, 8'h00, 8'h44, 1'b0, 8'h00, 7'b01_00_1_00}, // R7 rd same cycle as act completion
      {4'd8,  8'h68, 1'b0, 8'h3C, 8'h44, 1'b0, 8'h12, 7'b00_01_0_00}, // R8 rd pc0 b1 open
      {4'd10, 8'hC5, 1'b0, 8'h00, 8'hA8, 1'b0, 8'h00, 7'b10_00_1_00}, // R10 act pc1 b2 done, wr rejected
      {4'd10, 8'h84, 1'b0, 8'h00, 8'hA8, 1'b0, 8'h00, 7'b01_10_0_00}, // R10 pre pc0 and wr pc1 together
      {4'd10, 8'h00, 1'b0, 8'h00, 8'h48, 1'b0, 8'h00, 7'b00_00_1_00}, // R10 pc0 b2 closed while pc1 b2 open
      {4'd5,  8'h00, 1'b0, 8'h00, 8'h44, 1'b0, 8'h00, 7'b00_00_1_00}, // R5 pc0 b1 closed by precharge
      {4'd4,  8'h44, 1'b0, 8'h11, 8'h00, 1'b0, 8'h00, 7'b00_00_0_00}, // R4 act pc0 b1, first half
      {4'd1,  8'hC0, 1'b1, 8'h00, 8'h00, 1'b0, 8'h00, 7'b00_00_0_10}, // R1 bad parity on second half
      {4'd12, 8'hC0, 1'b0, 8'h00, 8'h00, 1'b0, 8'h00, 7'b00_00_0_00}, // R12 stray continuation
      {4'd2,  8'h00, 1'b0, 8'h00, 8'h68, 1'b1, 8'h00, 7'b00_00_0_01}, // R2 bad column parity
      {4'd6,  8'h4C, 1'b0, 8'h00, 8'h00, 1'b0, 8'h00, 7'b00_00_0_00}, // R6 act pc0 b3, first half
      {4'd6,  8'hA8, 1'b0, 8'h00, 8'h00, 1'b0, 8'h00, 7'b10_00_1_00}, // R6 pre pc1 b2 interrupts
      {4'd5,  8'h00, 1'b0, 8'h00, 8'h68, 1'b0, 8'h00, 7'b00_00_1_00}, // R5 pc1 b2 now closed
      {4'd12, 8'hC0, 1'b0, 8'h00, 8'h00, 1'b0, 8'h00, 7'b00_00_0_00}, // R12 no pending after interrupt
      {4'd12, 8'h00, 1'b0, 8'h00, 8'h00, 1'b0, 8'h00, 7'b00_00_0_00}  // R12 idle
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic step(input logic [7:0] rr, input logic rbad, input logic [7:0] rf,
                       input logic [7:0] cr, input logic cbad, input logic [7:0] cf);
      row_rise = rr; row_rise_par = (^rr) ^ rbad;
      row_fall = rf; row_fall_par = ^rf;
      col_rise = cr; col_rise_par = (^cr) ^ cbad;
      col_fall = cf; col_fall_par = ^cf;
      @(negedge clk);
   endtask

   function automatic logic [31:0] all_out();
      return {22'd0, pc_row_vld, pc_col_vld, pc_dvalid, row_par_err, col_par_err, proto_err};
   endfunction

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 5000 && !done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual %0d cycles expected under 5000", cyc);
         finish_run();
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R11 reset outputs", all_out(), 32'd0);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         logic [44:0] v;
         v = TV[i];
         step(v[40:33], v[32], v[31:24], v[23:16], v[15], v[14:7]);
         chk($sformatf("R%0d vector %0d", v[44:41], i),
             {25'd0, pc_row_vld, pc_col_vld, proto_err, row_par_err, col_par_err},
             {25'd0, v[6:0]});
      end
      repeat (6) step(8'h00, 1'b0, 8'h00, 8'h00, 1'b0, 8'h00);

      // R4 / R3: activate pc1 bank 5, row {9C, 2A}
      step(8'h74, 1'b0, 8'h9C, 8'h00, 1'b0, 8'h00);
      step(8'hEA, 1'b0, 8'h00, 8'h00, 1'b0, 8'h00);
      chk("R3 route pc1 only", {30'd0, pc_row_vld}, 32'd2);
      chk("R4 act flag", {31'd0, pc_row_act[1]}, 32'd1);
      chk("R4 bank", {29'd0, pc_row_bank[1]}, 32'd5);
      chk("R4 row addr", {18'd0, pc_row_addr[1]}, {18'd0, 8'h9C, 6'h2A});

      // R8: read pc1 bank 5, column {3, 5E}
      step(8'h00, 1'b0, 8'h00, 8'h77, 1'b0, 8'h5E);
      chk("R8 col vld", {30'd0, pc_col_vld}, 32'd2);
      chk("R8 rd flag", {31'd0, pc_col_wr[1]}, 32'd0);
      chk("R8 bank", {29'd0, pc_col_bank[1]}, 32'd5);
      chk("R8 col addr", {22'd0, pc_col_addr[1]}, {22'd0, 2'b11, 8'h5E});
      chk("R8 open row", {18'd0, pc_col_row[1]}, {18'd0, 8'h9C, 6'h2A});

      // R9: window in cycles C+3 and C+4 (DATA_LAT = 3)
      for (int k = 1; k <= 5; k++) begin
         step(8'h00, 1'b0, 8'h00, 8'h00, 1'b0, 8'h00);
         chk($sformatf("R9 dvalid step %0d", k), {30'd0, pc_dvalid},
             (k == 3 || k == 4) ? 32'd2 : 32'd0);
      end

      // R6: new activate while one is pending replaces it
      step(8'h40, 1'b0, 8'h11, 8'h00, 1'b0, 8'h00);
      step(8'h58, 1'b0, 8'h77, 8'h00, 1'b0, 8'h00);
      chk("R6 interrupt flagged", {29'd0, pc_row_vld, proto_err}, 32'd1);
      step(8'hC1, 1'b0, 8'h00, 8'h00, 1'b0, 8'h00);
      chk("R6 new act bank", {27'd0, pc_row_vld, pc_row_bank[0]}, {27'd0, 2'b01, 3'd6});
      chk("R6 new act row", {18'd0, pc_row_addr[0]}, {18'd0, 8'h77, 6'h01});

      // R5: precharge pc1 bank 5
      step(8'hB4, 1'b0, 8'h00, 8'h00, 1'b0, 8'h00);
      chk("R5 pre output", {26'd0, pc_row_vld, pc_row_act, pc_row_bank[1][1:0]}, {26'd0, 2'b10, 2'b00, 2'b01});

      // R11: reset closes pc0 bank 6
      rst_n = 1'b0;
      @(negedge clk);
      chk("R11 outputs in reset", all_out(), 32'd0);
      rst_n = 1'b1;
      step(8'h00, 1'b0, 8'h00, 8'h58, 1'b0, 8'h00);
      chk("R11 bank closed after reset", {29'd0, pc_col_vld, proto_err}, 32'd1);

      finish_run();
   end

endmodule